// File: doc/BRIEF.md
# Four-Channel Converter Scan Sequencer

This block is the digital control around an external sampling converter that has four analog inputs and returns 8-bit codes. An event from a timer starts work. In single mode the block converts the one input picked by a field of the control register. In scan mode it sweeps all four inputs in rising order. Each returned code is stored in a result register that belongs to its input. Software reads those registers through a small register port.

An interrupt flag tells software that results are ready. A control bit picks when the flag is raised: either when the first conversion after a trigger finishes, or when the fourth conversion (counted since the last control write) finishes. A separate enable bit can block the flag completely. Once raised, the flag stays set until software clears it with a status write. A busy bit in the status register shows that conversions are still pending.

The converter itself is outside the block. The block drives a channel number and a one-cycle start strobe, and waits for a one-cycle done strobe that comes with the 8-bit data.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, `adc_irq` is 0 and `conv_start` is 0.
- R2: When the block is idle and `tmr_trig` rises, `conv_start` pulses high for exactly one cycle. The pulse comes in the cycle after the clock edge that sampled the rise. In single mode (control bit 2 = 0), `conv_chan` then equals the control channel field, bits [1:0].
- R3: A code returned with `conv_done` is stored in the result register of the channel that was converted. Result register c sits at address 2+c and reads as the code on bits [7:0], with zeros above.
- R4: In scan mode (control bit 2 = 1), one trigger performs exactly four conversions on channels 0, 1, 2, 3 in that order. Each code is stored before the next start strobe.
- R5: A `tmr_trig` rise that arrives while conversions are pending is ignored: it starts no extra conversion.
- R6: Status register (address 1) bit 0 reads 1 from the cycle after a trigger is accepted until the last code of that trigger has been stored, and reads 0 when idle.
- R7: With control bit 3 = 0 and the enable set, the flag is set when the first conversion after each accepted trigger completes.
- R8: With control bit 3 = 1 and the enable set, the flag is set when every fourth conversion completes. Conversions are counted across triggers, and the count goes back to zero on every control-register write.
- R9: With control bit 10 = 0, the flag is never set.
- R10: The flag appears on `adc_irq` and on status bit 1. It stays set until a write to address 1 with bit 1 = 1 clears it.
- R11: The control register (address 0) reads back bits [3:0] and bit 10 as written, and reads every other bit as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address: 0 control, 1 status, 2..5 results |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| tmr_trig | input | 1 | Timer start event; its rising edge counts |
| conv_chan | output | 2 | Channel to convert |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_data | input | 8 | Code returned with conv_done |
| adc_irq | output | 1 | Interrupt flag |

## Verification
A wrong sequencer state shows up at `conv_chan` and `conv_start` within one conversion: a channel out of order, a fifth strobe, or a strobe after an ignored trigger. A wrong conversion counter does not show so quickly. It appears only as a flag raised on the wrong conversion, up to four conversions later, so the random stimulus mixes control writes and single triggers so that the counter passes through every phase. A result stored under the wrong channel shows only when that register is read, so all four are compared after every operation.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_t;

   localparam int ADDR_CTRL = 0;
   localparam int ADDR_STAT = 1;
   localparam int ADDR_RES0 = 2;

   localparam int BIT_SCAN  = 2;
   localparam int BIT_IRQPT = 3;
   localparam int BIT_IRQEN = 10;

   localparam int BIT_BUSY  = 0;
   localparam int BIT_FLAG  = 1;
endpackage

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter bit TRIG_EDGE = 1'b1,
   localparam int CH_W     = $clog2(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tmr_trig,
   input  logic            scan_mode,
   input  logic [CH_W-1:0] chan_sel,
   input  logic            conv_done,
   output logic            conv_start,
   output logic [CH_W-1:0] conv_chan,
   output logic            busy,
   output logic            scan_act,
   output logic            res_we,
   output logic [CH_W-1:0] res_ch,
   output logic            first_done
);
   seq_state_t      state_q;
   logic [CH_W-1:0] cur_q;
   logic            scan_q;
   logic            first_q;
   logic            trig_evt;

   if (TRIG_EDGE) begin : g_edge
      logic trig_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) trig_q <= 1'b0;
         else        trig_q <= tmr_trig;
      end
      assign trig_evt = tmr_trig & ~trig_q;
   end else begin : g_level
      assign trig_evt = tmr_trig;
   end

   logic last_ch;
   assign last_ch = (cur_q == CH_W'(NUM_CH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cur_q   <= '0;
         scan_q  <= 1'b0;
         first_q <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (trig_evt) begin
                  cur_q   <= scan_mode ? '0 : chan_sel;
                  scan_q  <= scan_mode;
                  first_q <= 1'b1;
                  state_q <= SEQ_ISSUE;
               end
            end
            SEQ_ISSUE: state_q <= SEQ_WAIT;
            SEQ_WAIT: begin
               if (conv_done) begin
                  first_q <= 1'b0;
                  if (scan_q && !last_ch) begin
                     cur_q   <= cur_q + 1'b1;
                     state_q <= SEQ_ISSUE;
                  end else begin
                     state_q <= SEQ_IDLE;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign conv_start = (state_q == SEQ_ISSUE);
   assign conv_chan  = cur_q;
   assign busy       = (state_q != SEQ_IDLE);
   assign scan_act   = scan_q;
   assign res_we     = (state_q == SEQ_WAIT) && conv_done;
   assign res_ch     = cur_q;
   assign first_done = res_we && first_q;
endmodule

// File: rtl/adc_scan_irq.sv
module adc_scan_irq #(
   parameter int NUM_CH = 4,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic res_we,
   input  logic first_done,
   input  logic irq_pt,
   input  logic irq_en,
   input  logic cnt_clr,
   input  logic flag_clr,
   output logic irq_flag
);
   logic [CH_W-1:0] cnt_q;
   logic            nth_done;
   logic            set_flag;

   assign nth_done = res_we && (cnt_q == CH_W'(NUM_CH - 1));
   assign set_flag = irq_en && (irq_pt ? nth_done : first_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_clr) cnt_q <= '0;
      else if (res_we)  cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq_flag <= 1'b0;
      else if (set_flag) irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
   end
endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int RES_W  = 8,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic              irq_flag,
   input  logic              res_we,
   input  logic [CH_W-1:0]   res_ch,
   input  logic [RES_W-1:0]  res_data,
   output logic [CH_W-1:0]   chan_sel,
   output logic              scan_mode,
   output logic              irq_pt,
   output logic              irq_en,
   output logic              ctrl_wr,
   output logic              flag_clr
);
   localparam logic [DATA_W-1:0] CTRL_MASK =
      DATA_W'((1 << CH_W) - 1) | DATA_W'(1 << BIT_SCAN) |
      DATA_W'(1 << BIT_IRQPT)  | DATA_W'(1 << BIT_IRQEN);

   logic [DATA_W-1:0] ctrl_q;
   logic [RES_W-1:0]  res_q [NUM_CH];
   logic              sel_ctrl, sel_stat;

   assign sel_ctrl = (reg_addr == ADDR_W'(ADDR_CTRL));
   assign sel_stat = (reg_addr == ADDR_W'(ADDR_STAT));
   assign ctrl_wr  = reg_wr && sel_ctrl;
   assign flag_clr = reg_wr && sel_stat && reg_wdata[BIT_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= reg_wdata & CTRL_MASK;
   end

   assign chan_sel  = ctrl_q[CH_W-1:0];
   assign scan_mode = ctrl_q[BIT_SCAN];
   assign irq_pt    = ctrl_q[BIT_IRQPT];
   assign irq_en    = ctrl_q[BIT_IRQEN];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_res
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              res_q[c] <= '0;
         else if (res_we && res_ch == CH_W'(c))   res_q[c] <= res_data;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) begin
         reg_rdata = ctrl_q;
      end else if (sel_stat) begin
         reg_rdata[BIT_BUSY] = busy;
         reg_rdata[BIT_FLAG] = irq_flag;
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (reg_addr == ADDR_W'(ADDR_RES0 + c)) reg_rdata = DATA_W'(res_q[c]);
      end
   end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int RES_W     = 8,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 3,
   parameter bit TRIG_EDGE = 1'b1,
   localparam int CH_W     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tmr_trig,
   output logic [CH_W-1:0]   conv_chan,
   output logic              conv_start,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   output logic              adc_irq
);
   if (NUM_CH != 2 && NUM_CH != 4) begin : g_bad_ch
      $error("adc_scan_ctrl: NUM_CH must be 2 or 4");
   end
   if (DATA_W <= BIT_IRQEN || RES_W > DATA_W) begin : g_bad_w
      $error("adc_scan_ctrl: DATA_W too small for control fields or results");
   end
   if ((1 << ADDR_W) < ADDR_RES0 + NUM_CH) begin : g_bad_a
      $error("adc_scan_ctrl: ADDR_W cannot reach all result registers");
   end

   logic            busy, scan_act, res_we, first_done;
   logic [CH_W-1:0] res_ch, chan_sel;
   logic            scan_mode, irq_pt, irq_en, ctrl_wr, flag_clr, irq_flag;

   adc_scan_seq #(.NUM_CH(NUM_CH), .TRIG_EDGE(TRIG_EDGE)) seq_i (
      .clk(clk), .rst_n(rst_n), .tmr_trig(tmr_trig),
      .scan_mode(scan_mode), .chan_sel(chan_sel), .conv_done(conv_done),
      .conv_start(conv_start), .conv_chan(conv_chan), .busy(busy),
      .scan_act(scan_act), .res_we(res_we), .res_ch(res_ch),
      .first_done(first_done)
   );

   adc_scan_regs #(.NUM_CH(NUM_CH), .RES_W(RES_W), .DATA_W(DATA_W),
                   .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .irq_flag(irq_flag), .res_we(res_we), .res_ch(res_ch),
      .res_data(conv_data), .chan_sel(chan_sel), .scan_mode(scan_mode),
      .irq_pt(irq_pt), .irq_en(irq_en), .ctrl_wr(ctrl_wr),
      .flag_clr(flag_clr)
   );

   adc_scan_irq #(.NUM_CH(NUM_CH)) irq_i (
      .clk(clk), .rst_n(rst_n), .res_we(res_we), .first_done(first_done),
      .irq_pt(irq_pt), .irq_en(irq_en), .cnt_clr(ctrl_wr),
      .flag_clr(flag_clr), .irq_flag(irq_flag)
   );

   assign adc_irq = irq_flag;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              tmr_trig,
   input logic              conv_start,
   input logic [CH_W-1:0]   conv_chan,
   input logic              conv_done,
   input logic              adc_irq,
   input logic              busy,
   input logic              scan_act,
   input logic              irq_en
);
   logic stat_clr;
   assign stat_clr = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT)) && reg_wdata[BIT_FLAG];

   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tmr_trig));

   p_scan_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start && scan_act && $past(conv_done) |->
         conv_chan == CH_W'($past(conv_chan) + 1'b1));

   p_chan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !conv_done && !conv_start |=> $stable(conv_chan));

   p_set_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_irq) |-> $past(conv_done));

   p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en && !adc_irq |=> !adc_irq);

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      adc_irq && !stat_clr |=> adc_irq);
endmodule

bind adc_scan_ctrl adc_scan_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .tmr_trig(tmr_trig), .conv_start(conv_start),
   .conv_chan(conv_chan), .conv_done(conv_done), .adc_irq(adc_irq),
   .busy(busy), .scan_act(scan_act), .irq_en(irq_en)
);

// File: tb/adc_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb_top;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tmr_trig = 1'b0;
   logic [1:0]  conv_chan;
   logic        conv_start;
   logic        conv_done = 1'b0;
   logic [7:0]  conv_data = '0;
   logic        adc_irq;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   adc_scan_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_trig(tmr_trig),
      .conv_chan(conv_chan), .conv_start(conv_start), .conv_done(conv_done),
      .conv_data(conv_data), .adc_irq(adc_irq)
   );

   // converter stub: fixed latency, random code, logs every conversion
   int         lat_cnt = 0;
   logic [1:0] pend_ch = '0;
   logic [7:0] pend_dat = '0;
   int         n_start = 0;
   int         n_done = 0;
   logic [1:0] log_ch [1024];
   logic [7:0] log_dat [1024];

   always @(posedge clk) begin
      conv_done <= 1'b0;
      if (lat_cnt > 0) begin
         lat_cnt <= lat_cnt - 1;
         if (lat_cnt == 1) begin
            conv_done <= 1'b1;
            conv_data <= pend_dat;
            log_ch[n_done]  = pend_ch;
            log_dat[n_done] = pend_dat;
            n_done = n_done + 1;
         end
      end
      if (conv_start) begin
         lat_cnt  <= LAT;
         pend_ch  <= conv_chan;
         pend_dat <= 8'($urandom);
         n_start  = n_start + 1;
      end
   end

   // bench model
   logic [15:0] m_ctrl = '0;
   logic [7:0]  m_res [4];
   logic        m_flag = 1'b0;
   int          m_cnt = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 3'd0) begin m_ctrl = d & 16'h040F; m_cnt = 0; end
      if (a == 3'd1 && d[1]) m_flag = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic trigger(input bit check_strobe);
      @(negedge clk);
      tmr_trig = 1'b1;
      @(negedge clk);
      tmr_trig = 1'b0;
      if (check_strobe) begin
         chk("R2 strobe", {31'd0, conv_start}, 32'd1);
         if (!m_ctrl[2]) chk("R2 chan", {30'd0, conv_chan}, {30'd0, m_ctrl[1:0]});
         @(negedge clk);
         chk("R2 one cycle", {31'd0, conv_start}, 32'd0);
      end
   endtask

   task automatic wait_idle();
      logic [15:0] v;
      for (int i = 0; i < 1000; i++) begin
         rd(3'd1, v);
         if (!v[0]) return;
      end
      chk("R6 idle timeout", 32'd1, 32'd0);
   endtask

   // one operation: trigger, optional extra trigger while busy, then compare
   task automatic run_op(input bit extra, input bit check_strobe);
      int          s0, d0, nexp;
      logic [15:0] v;
      s0 = n_start; d0 = n_done;
      nexp = m_ctrl[2] ? 4 : 1;
      trigger(check_strobe);
      rd(3'd1, v);
      chk("R6 busy", {31'd0, v[0]}, 32'd1);
      if (extra) begin
         @(negedge clk) tmr_trig = 1'b1;
         @(negedge clk) tmr_trig = 1'b0;
      end
      wait_idle();
      chk(extra ? "R5 ignored trigger count" : "R4 conversion count",
          n_start - s0, nexp);
      for (int j = 0; j < n_done - d0; j++) begin
         logic [1:0] ech;
         ech = m_ctrl[2] ? 2'(j) : m_ctrl[1:0];
         chk(m_ctrl[2] ? "R4 order" : "R2 chan", {30'd0, log_ch[d0+j]}, {30'd0, ech});
         m_res[log_ch[d0+j]] = log_dat[d0+j];
         m_cnt = (m_cnt + 1) % 4;
         if (m_ctrl[10]) begin
            if (m_ctrl[3] ? (m_cnt == 0) : (j == 0)) m_flag = 1'b1;
         end
      end
      for (int c = 0; c < 4; c++) begin
         rd(3'(2 + c), v);
         chk("R3 result", {16'd0, v}, {24'd0, m_res[c]});
      end
      rd(3'd1, v);
      chk(m_ctrl[10] ? (m_ctrl[3] ? "R8 flag" : "R7 flag") : "R9 flag",
          {30'd0, v[1:0]}, {30'd0, m_flag, 1'b0});
      chk("R10 irq pin", {31'd0, adc_irq}, {31'd0, m_flag});
   endtask

   initial begin
      logic [15:0] v;
      void'($urandom(32'h5EED_0417));
      for (int c = 0; c < 4; c++) m_res[c] = '0;
      repeat (4) @(negedge clk);
      chk("R1 strobe", {31'd0, conv_start}, 32'd0);
      chk("R1 irq", {31'd0, adc_irq}, 32'd0);
      rst_n = 1'b1;
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk("R1 register", {16'd0, v}, 32'd0);
      end

      // R11 readback masking
      wr(3'd0, 16'hFFFF);
      rd(3'd0, v);
      chk("R11 ctrl readback", {16'd0, v}, 32'h040F);

      // single ch2, first-conversion interrupt (R2, R3, R7)
      wr(3'd0, 16'h0402);
      run_op(1'b0, 1'b1);
      repeat (5) @(negedge clk);
      chk("R10 sticky", {31'd0, adc_irq}, 32'd1);
      wr(3'd1, 16'h0002);
      chk("R10 clear", {31'd0, adc_irq}, 32'd0);

      // scan with fourth-conversion interrupt and ignored trigger (R4, R5, R8)
      wr(3'd0, 16'h040C);
      run_op(1'b1, 1'b1);
      wr(3'd1, 16'h0002);

      // enable off: scan never flags (R9)
      wr(3'd0, 16'h0004);
      run_op(1'b0, 1'b0);
      run_op(1'b0, 1'b0);

      // fourth conversion over single triggers (R8)
      wr(3'd0, 16'h0409);
      for (int k = 0; k < 4; k++) begin
         run_op(1'b0, 1'b1);
         chk("R8 nth", {31'd0, adc_irq}, {31'd0, (k == 3)});
      end
      wr(3'd1, 16'h0002);

      // random mix
      for (int it = 0; it < 40; it++) begin
         if ($urandom_range(1, 0) == 1) wr(3'd0, 16'($urandom));
         if ($urandom_range(3, 0) == 0) wr(3'd1, 16'h0002);
         run_op(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule